// File: doc/BRIEF.md
# Sequence Generator Control Register Bank

This block is a 32-bit Wishbone slave that gives a host processor a small bank of control and status words for a sequence-generator peripheral. It decodes word addresses inside a fixed 64-byte window at a base address and answers each single read or write with a one-cycle acknowledge. The bank holds two fixed identity words, a control word and a clock-select word that drive the generator, a live readback of the generator output, a scratch loopback pair, a software-raised interrupt line, and a diagnostic word that firmware writes to report progress or a fault.

The bus follows the classic single-transfer handshake. A request is offered while cycle and strobe are both high. The acknowledge is the slave's ready: the master holds address, data, write enable and byte selects stable until it sees acknowledge, then drops strobe. The slave always takes a request on the first cycle it sees it, so every access costs exactly one wait state and the master never waits longer. Read data is valid in the acknowledge cycle and is zero at all other times.

The word map is fixed because firmware depends on it. The offsets from the base are: 0x00 register count (reads 9), 0x04 identity (reads 0x4669626F), 0x08 interrupt set/clear, 0x0C control, 0x10 clock select, 0x14 generator value, 0x18 scratch write, 0x1C scratch read, 0x20 diagnostic word. Address bits 1:0 are ignored.

Top module: `seqgen_csr`

## Requirements
- R1: `wb_ack_o` goes high in the cycle after a request is first seen with `wb_cyc_i` and `wb_stb_i` both high, stays high for exactly one cycle, and stays low while either of them is low.
- R2: A read at offset 0x00 returns 9 and a read at offset 0x04 returns 0x4669626F.
- R3: A write to offset 0x0C loads the low CTRL_W bits (8 by default) into `gen_ctrl_o`. A read there returns that value with the upper bits zero. Values 0, 1 and 0xA5 read back as written.
- R4: A write to offset 0x10 loads the low CLKSEL_W bits (8 by default) into `gen_clksel_o`. A read there returns that value with the upper bits zero.
- R5: A read at offset 0x14 returns `gen_value_i` as sampled in the cycle the request is taken.
- R6: A word written at offset 0x18 is returned by reads at offset 0x1C. A read at 0x18 returns 0, and a write at 0x1C changes nothing.
- R7: A write at offset 0x08 with byte select 0 set loads data bit 0 into `irq_o`: 1 raises the interrupt and 0 clears it. `irq_o` changes together with the acknowledge. A read at 0x08 returns `irq_o` in bit 0 and zeros above it.
- R8: A write at offset 0x20 stores the full word on `panic_word_o` and pulses `panic_pulse_o` high for one cycle, in the acknowledge cycle. A read at 0x20 returns 0.
- R9: On a write to a writable word, byte lane k (data bits 8k+7:8k) is updated only if `wb_sel_i[k]` is 1. A write with all selects 0 changes nothing.
- R10: A request at an unmapped offset (0x24 to 0x3C), or at an address outside the 64-byte window, is still acknowledged. It reads 0 and a write there changes nothing.
- R11: While `rst_i` is high at a clock edge, the control, clock-select, scratch, interrupt and diagnostic words are cleared to 0, and acknowledge and the pulse are cleared. Reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Request strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W (32) | Byte address; bits 1:0 ignored |
| wb_sel_i | input | DATA_W/8 (4) | Byte lane selects for writes |
| wb_dat_i | input | DATA_W (32) | Write data |
| wb_dat_o | output | DATA_W (32) | Read data, valid with acknowledge, else 0 |
| wb_ack_o | output | 1 | Transfer acknowledge (one cycle) |
| gen_value_i | input | VAL_W (32) | Current generator output for readback |
| gen_ctrl_o | output | CTRL_W (8) | Generator control word |
| gen_clksel_o | output | CLKSEL_W (8) | Generator clock-select code |
| irq_o | output | 1 | Software-raised interrupt line |
| panic_word_o | output | DATA_W (32) | Last diagnostic word written |
| panic_pulse_o | output | 1 | One-cycle pulse per diagnostic write |

## Verification
The bound checker watches, on every cycle, properties that can be stated from the ports alone:
- the acknowledge is one cycle long and only follows a request;
- the control and clock-select outputs hold unless a write to their word was taken;
- the interrupt line rises or falls only after a write to its word with the matching data bit;
- the diagnostic pulse lines up with an acknowledge;
- the writable state reads zero after a reset edge.

Other behaviour can only be shown by the bench's scenarios, because it concerns read data or lack of effect:
- the values of the read map at all sixteen offsets;
- the scratch loopback;
- the byte-lane merge across all sixteen select patterns;
- the silence of unmapped and out-of-window writes.

// File: rtl/seqgen_csr_pkg.sv
package seqgen_csr_pkg;

  // Word slots inside the window; firmware depends on this order.
  localparam int SLOT_COUNT  = 0;
  localparam int SLOT_IDENT  = 1;
  localparam int SLOT_IRQ    = 2;
  localparam int SLOT_CTRL   = 3;
  localparam int SLOT_CLKSEL = 4;
  localparam int SLOT_VALUE  = 5;
  localparam int SLOT_WDATA  = 6;
  localparam int SLOT_RDATA  = 7;
  localparam int SLOT_PANIC  = 8;
  localparam int NUM_REGS    = 9;

  localparam logic [31:0] IDENT_WORD = 32'h4669_626F;

endpackage

// File: rtl/seqgen_csr_decode.sv
module seqgen_csr_decode
  import seqgen_csr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h3000_0000,
  parameter int WIN_BITS = 6,
  localparam int IDX_W = WIN_BITS - 2
) (
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic              ack_q_i,
  input  logic [ADDR_W-1:0] adr_i,
  output logic              accept_o,
  output logic              rd_accept_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_REGS-1:0] wr_stb_o
);

  localparam logic [ADDR_W-WIN_BITS-1:0] BASE_HI = BASE[ADDR_W-1:WIN_BITS];

  logic [1:0] unused_byte_lsb;
  assign unused_byte_lsb = adr_i[1:0];

  // A request is taken once; the cycle carrying the ack is not a new request.
  assign accept_o    = cyc_i && stb_i && !ack_q_i;
  assign rd_accept_o = accept_o && !we_i;
  assign hit_o       = (adr_i[ADDR_W-1:WIN_BITS] == BASE_HI);
  assign idx_o       = adr_i[WIN_BITS-1:2];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wstb
    assign wr_stb_o[i] = accept_o && we_i && hit_o && (idx_o == IDX_W'(i));
  end

endmodule

// File: rtl/seqgen_csr_field.sv
module seqgen_csr_field #(
  parameter int W = 8,
  localparam int NB = (W + 7) / 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          we_i,
  input  logic [NB-1:0] sel_i,
  input  logic [W-1:0]  d_i,
  output logic [W-1:0]  q_o
);

  // One independently enabled register per byte lane; the last lane may be partial.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam int LO = b * 8;
    localparam int HI = (LO + 7 < W) ? LO + 7 : W - 1;
    logic [HI-LO:0] lane_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        lane_q <= '0;
      end else if (we_i && sel_i[b]) begin
        lane_q <= d_i[HI:LO];
      end
    end

    assign q_o[HI:LO] = lane_q;
  end

endmodule

// File: rtl/seqgen_csr_rdmux.sv
module seqgen_csr_rdmux
  import seqgen_csr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter int CTRL_W   = 8,
  parameter int CLKSEL_W = 8,
  parameter int VAL_W    = 32
) (
  input  logic                hit_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                irq_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic [CLKSEL_W-1:0] clksel_i,
  input  logic [VAL_W-1:0]    value_i,
  input  logic [DATA_W-1:0]   scratch_i,
  output logic [DATA_W-1:0]   rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      case (int'(idx_i))
        SLOT_COUNT:  rdata_o = DATA_W'(NUM_REGS);
        SLOT_IDENT:  rdata_o = DATA_W'(IDENT_WORD);
        SLOT_IRQ:    rdata_o[0] = irq_i;
        SLOT_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_i;
        SLOT_CLKSEL: rdata_o[CLKSEL_W-1:0] = clksel_i;
        SLOT_VALUE:  rdata_o[VAL_W-1:0] = value_i;
        SLOT_RDATA:  rdata_o = scratch_i;
        // write-only words and unmapped slots read as zero
        default:     rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/seqgen_csr.sv
module seqgen_csr
  import seqgen_csr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h3000_0000,
  parameter int WIN_BITS = 6,
  parameter int CTRL_W   = 8,
  parameter int CLKSEL_W = 8,
  parameter int VAL_W    = 32,
  localparam int SEL_W   = DATA_W / 8,
  localparam int IDX_W   = WIN_BITS - 2
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [ADDR_W-1:0]   wb_adr_i,
  input  logic [SEL_W-1:0]    wb_sel_i,
  input  logic [DATA_W-1:0]   wb_dat_i,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic                wb_ack_o,
  input  logic [VAL_W-1:0]    gen_value_i,
  output logic [CTRL_W-1:0]   gen_ctrl_o,
  output logic [CLKSEL_W-1:0] gen_clksel_o,
  output logic                irq_o,
  output logic [DATA_W-1:0]   panic_word_o,
  output logic                panic_pulse_o
);

  localparam int CTRL_NB   = (CTRL_W + 7) / 8;
  localparam int CLKSEL_NB = (CLKSEL_W + 7) / 8;

  logic                accept, rd_accept, hit;
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] wr_stb;
  logic [DATA_W-1:0]   scratch_q;
  logic [DATA_W-1:0]   rdata;
  logic                ack_q, pulse_q;
  logic [DATA_W-1:0]   dat_q;

  // read-only slots never need a write strobe
  logic [3:0] unused_ro_stb;
  assign unused_ro_stb = {wr_stb[SLOT_COUNT], wr_stb[SLOT_IDENT],
                          wr_stb[SLOT_VALUE], wr_stb[SLOT_RDATA]};

  seqgen_csr_decode #(
    .ADDR_W  (ADDR_W),
    .BASE    (BASE),
    .WIN_BITS(WIN_BITS)
  ) u_decode (
    .cyc_i      (wb_cyc_i),
    .stb_i      (wb_stb_i),
    .we_i       (wb_we_i),
    .ack_q_i    (ack_q),
    .adr_i      (wb_adr_i),
    .accept_o   (accept),
    .rd_accept_o(rd_accept),
    .hit_o      (hit),
    .idx_o      (idx),
    .wr_stb_o   (wr_stb)
  );

  seqgen_csr_field #(.W(1)) u_irq (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(wr_stb[SLOT_IRQ]),
    .sel_i(wb_sel_i[0]), .d_i(wb_dat_i[0]), .q_o(irq_o)
  );

  seqgen_csr_field #(.W(CTRL_W)) u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(wr_stb[SLOT_CTRL]),
    .sel_i(wb_sel_i[CTRL_NB-1:0]), .d_i(wb_dat_i[CTRL_W-1:0]), .q_o(gen_ctrl_o)
  );

  seqgen_csr_field #(.W(CLKSEL_W)) u_clksel (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(wr_stb[SLOT_CLKSEL]),
    .sel_i(wb_sel_i[CLKSEL_NB-1:0]), .d_i(wb_dat_i[CLKSEL_W-1:0]), .q_o(gen_clksel_o)
  );

  seqgen_csr_field #(.W(DATA_W)) u_scratch (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(wr_stb[SLOT_WDATA]),
    .sel_i(wb_sel_i), .d_i(wb_dat_i), .q_o(scratch_q)
  );

  seqgen_csr_field #(.W(DATA_W)) u_panic (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(wr_stb[SLOT_PANIC]),
    .sel_i(wb_sel_i), .d_i(wb_dat_i), .q_o(panic_word_o)
  );

  seqgen_csr_rdmux #(
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .CTRL_W  (CTRL_W),
    .CLKSEL_W(CLKSEL_W),
    .VAL_W   (VAL_W)
  ) u_rdmux (
    .hit_i    (hit),
    .idx_i    (idx),
    .irq_i    (irq_o),
    .ctrl_i   (gen_ctrl_o),
    .clksel_i (gen_clksel_o),
    .value_i  (gen_value_i),
    .scratch_i(scratch_q),
    .rdata_o  (rdata)
  );

  // Response stage: ack, read data and the diagnostic pulse share one register level.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_q   <= 1'b0;
      dat_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      ack_q   <= accept;
      dat_q   <= rd_accept ? rdata : '0;
      pulse_q <= wr_stb[SLOT_PANIC];
    end
  end

  assign wb_ack_o      = ack_q;
  assign wb_dat_o      = dat_q;
  assign panic_pulse_o = pulse_q;

endmodule

// File: rtl/seqgen_csr_chk.sv
module seqgen_csr_chk #(
  parameter int ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h3000_0000,
  parameter int CTRL_W   = 8,
  parameter int CLKSEL_W = 8,
  parameter int DATA_W   = 32
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                cyc_i,
  input logic                stb_i,
  input logic                we_i,
  input logic [ADDR_W-3:0]   word_adr_i,
  input logic                sel0_i,
  input logic                dat0_i,
  input logic                ack_i,
  input logic                irq_i,
  input logic [CTRL_W-1:0]   ctrl_i,
  input logic [CLKSEL_W-1:0] clksel_i,
  input logic [DATA_W-1:0]   panic_word_i,
  input logic                panic_pulse_i
);

  localparam logic [ADDR_W-1:0] A_IRQ    = BASE + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CTRL   = BASE + ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_CLKSEL = BASE + ADDR_W'(16);

  logic primed = 1'b0;
  always_ff @(posedge clk_i) primed <= 1'b1;

  logic taken_wr;
  assign taken_wr = cyc_i && stb_i && we_i && !ack_i;

  logic wr_irq, wr_ctrl, wr_clksel;
  assign wr_irq    = taken_wr && (word_adr_i == A_IRQ[ADDR_W-1:2]);
  assign wr_ctrl   = taken_wr && (word_adr_i == A_CTRL[ADDR_W-1:2]);
  assign wr_clksel = taken_wr && (word_adr_i == A_CLKSEL[ADDR_W-1:2]);

  // R1
  ack_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_i |=> !ack_i);

  // R1
  ack_after_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_i |-> $past(cyc_i && stb_i));

  // R3
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(wr_ctrl) |-> $stable(ctrl_i));

  // R4
  clksel_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(wr_clksel) |-> $stable(clksel_i));

  // R7
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_i) |-> $past(wr_irq && sel0_i && dat0_i));

  // R7
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(irq_i) |-> $past(wr_irq && sel0_i && !dat0_i));

  // R8
  panic_with_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    panic_pulse_i |-> ack_i);

  // R11
  reset_clear_chk: assert property (@(posedge clk_i)
    (primed && $past(rst_i)) |-> (ctrl_i == '0 && clksel_i == '0 && !irq_i &&
                                  panic_word_i == '0 && !ack_i && !panic_pulse_i));

endmodule

bind seqgen_csr seqgen_csr_chk #(
  .ADDR_W  (ADDR_W),
  .BASE    (BASE),
  .CTRL_W  (CTRL_W),
  .CLKSEL_W(CLKSEL_W),
  .DATA_W  (DATA_W)
) u_seqgen_csr_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .cyc_i        (wb_cyc_i),
  .stb_i        (wb_stb_i),
  .we_i         (wb_we_i),
  .word_adr_i   (wb_adr_i[ADDR_W-1:2]),
  .sel0_i       (wb_sel_i[0]),
  .dat0_i       (wb_dat_i[0]),
  .ack_i        (wb_ack_o),
  .irq_i        (irq_o),
  .ctrl_i       (gen_ctrl_o),
  .clksel_i     (gen_clksel_o),
  .panic_word_i (panic_word_o),
  .panic_pulse_i(panic_pulse_o)
);

// File: tb/seqgen_csr_bench.sv
`timescale 1ns/1ps
module seqgen_csr_bench;

  localparam logic [31:0] BASE = 32'h3000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_cyc = 1'b0, b_stb = 1'b0, b_we = 1'b0;
  logic [31:0] b_adr = '0, b_dat = '0;
  logic [3:0]  b_sel = '0;
  logic [31:0] gen_value = 32'h1234_5678;
  logic [31:0] dat_o, panic_word;
  logic        ack, irq, panic_pulse;
  logic [7:0]  gen_ctrl, gen_clksel;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] rd_last;
  logic        pulse_seen;

  always #5 clk = ~clk;

  seqgen_csr u_seqgen_csr (
    .clk_i(clk), .rst_i(rst),
    .wb_cyc_i(b_cyc), .wb_stb_i(b_stb), .wb_we_i(b_we),
    .wb_adr_i(b_adr), .wb_sel_i(b_sel), .wb_dat_i(b_dat),
    .wb_dat_o(dat_o), .wb_ack_o(ack),
    .gen_value_i(gen_value), .gen_ctrl_o(gen_ctrl), .gen_clksel_o(gen_clksel),
    .irq_o(irq), .panic_word_o(panic_word), .panic_pulse_o(panic_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  // One bus transfer; the ack lands one edge after the request is taken.
  task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] s);
    @(negedge clk);
    b_cyc = 1'b1; b_stb = 1'b1; b_we = w; b_adr = a; b_dat = d; b_sel = s;
    @(negedge clk);
    check("R1 ack one cycle after request", 32'(ack), 32'd1);
    rd_last = dat_o;
    pulse_seen = panic_pulse;
    b_cyc = 1'b0; b_stb = 1'b0; b_we = 1'b0; b_sel = '0;
    @(negedge clk);
    check("R1 ack lasts one cycle", 32'(ack), 32'd0);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    xfer(1'b1, a, d, s);
  endtask

  task automatic rd(input logic [31:0] a);
    xfer(1'b0, a, 32'h0, 4'h0);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] s);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (s[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  initial begin
    logic [31:0] scr_model;
    logic [31:0] exp;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state at the ports
    check("R11 ack after reset", 32'(ack), 32'd0);
    check("R11 irq after reset", 32'(irq), 32'd0);
    check("R11 ctrl after reset", 32'(gen_ctrl), 32'd0);
    check("R11 clksel after reset", 32'(gen_clksel), 32'd0);
    check("R11 panic word after reset", panic_word, 32'd0);
    check("R11 pulse after reset", 32'(panic_pulse), 32'd0);

    // Sweep every slot in the window: R2 constants, R5 value, R10 unmapped, R11 zeros
    for (int i = 0; i < 16; i++) begin
      rd(BASE + 32'(i * 4));
      case (i)
        0: exp = 32'd9;
        1: exp = 32'h4669_626F;
        5: exp = gen_value;
        default: exp = 32'd0;
      endcase
      if (i < 2) check("R2 identity read", rd_last, exp);
      else if (i == 5) check("R5 value read", rd_last, exp);
      else if (i > 8) check("R10 unmapped read", rd_last, exp);
      else check("R11 cleared word read", rd_last, exp);
    end
    rd(BASE + 32'h40);
    check("R10 read outside window", rd_last, 32'd0);
    rd(BASE - 32'h3C);
    check("R10 read below window", rd_last, 32'd0);

    // R3 control readback
    wr(BASE + 32'h0C, 32'd0, 4'hF);
    rd(BASE + 32'h0C);
    check("R3 control reads 0", rd_last, 32'd0);
    wr(BASE + 32'h0C, 32'd1, 4'hF);
    rd(BASE + 32'h0C);
    check("R3 control reads 1", rd_last, 32'd1);
    check("R3 control drives port", 32'(gen_ctrl), 32'd1);
    wr(BASE + 32'h0C, 32'hFFFF_FFA5, 4'hF);
    rd(BASE + 32'h0C);
    check("R3 control upper bits zero", rd_last, 32'h0000_00A5);
    wr(BASE + 32'h0C, 32'h0000_0033, 4'h0);
    check("R9 control no select no change", 32'(gen_ctrl), 32'h0000_00A5);

    // R4 clock select
    wr(BASE + 32'h10, 32'h0000_0002, 4'hF);
    rd(BASE + 32'h10);
    check("R4 clock select readback", rd_last, 32'd2);
    check("R4 clock select port", 32'(gen_clksel), 32'd2);

    // R6 scratch loopback
    wr(BASE + 32'h18, 32'hDEAD_BEEF, 4'hF);
    rd(BASE + 32'h1C);
    check("R6 scratch loopback", rd_last, 32'hDEAD_BEEF);
    rd(BASE + 32'h18);
    check("R6 write word reads 0", rd_last, 32'd0);
    wr(BASE + 32'h1C, 32'h1111_1111, 4'hF);
    rd(BASE + 32'h1C);
    check("R6 read word ignores writes", rd_last, 32'hDEAD_BEEF);

    // R9 every byte-select pattern on the scratch word
    scr_model = 32'hDEAD_BEEF;
    for (int s = 0; s < 16; s++) begin
      logic [31:0] pat;
      pat = 32'h9E37_79B9 ^ (32'(s) * 32'h0101_0101);
      wr(BASE + 32'h18, pat, 4'(s));
      scr_model = merge(scr_model, pat, 4'(s));
      rd(BASE + 32'h1C);
      check("R9 byte select merge", rd_last, scr_model);
    end

    // R5 live value at several patterns
    for (int v = 0; v < 4; v++) begin
      gen_value = 32'hA5A5_0000 + 32'(v * 7919);
      rd(BASE + 32'h14);
      check("R5 value follows input", rd_last, gen_value);
    end

    // R7 interrupt raise and clear
    wr(BASE + 32'h08, 32'd1, 4'h1);
    check("R7 irq raised", 32'(irq), 32'd1);
    rd(BASE + 32'h08);
    check("R7 irq readback", rd_last, 32'd1);
    wr(BASE + 32'h08, 32'd0, 4'h1);
    check("R7 irq cleared", 32'(irq), 32'd0);
    wr(BASE + 32'h08, 32'd1, 4'hE);
    check("R9 irq needs lane 0 select", 32'(irq), 32'd0);
    wr(BASE + 32'h08, 32'd2, 4'hF);
    check("R7 only bit 0 raises irq", 32'(irq), 32'd0);

    // R8 diagnostic word
    wr(BASE + 32'h20, 32'h0BAD_F00D, 4'hF);
    check("R8 pulse with ack", 32'(pulse_seen), 32'd1);
    check("R8 pulse one cycle", 32'(panic_pulse), 32'd0);
    check("R8 panic word stored", panic_word, 32'h0BAD_F00D);
    rd(BASE + 32'h20);
    check("R8 panic reads 0", rd_last, 32'd0);
    check("R8 no pulse on read", 32'(pulse_seen), 32'd0);

    // R10 writes to unmapped offsets and aliases outside the window
    for (int off = 'h24; off < 'h40; off += 4) wr(BASE + 32'(off), 32'hFFFF_FFFF, 4'hF);
    wr(BASE + 32'h4C, 32'hFFFF_FFFF, 4'hF);
    wr(BASE + 32'h48, 32'hFFFF_FFFF, 4'hF);
    wr(BASE + 32'h58, 32'hFFFF_FFFF, 4'hF);
    check("R10 control untouched", 32'(gen_ctrl), 32'h0000_00A5);
    check("R10 irq untouched", 32'(irq), 32'd0);
    check("R10 clksel untouched", 32'(gen_clksel), 32'd2);
    rd(BASE + 32'h1C);
    check("R10 scratch untouched", rd_last, scr_model);

    // R1 no ack without both cycle and strobe
    @(negedge clk);
    b_cyc = 1'b1; b_stb = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 no ack with strobe low", 32'(ack), 32'd0);
    end
    b_cyc = 1'b0; b_stb = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R1 no ack with cycle low", 32'(ack), 32'd0);
    end
    b_stb = 1'b0;

    // R11 reset in the middle of operation
    wr(BASE + 32'h08, 32'd1, 4'h1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 irq cleared by reset", 32'(irq), 32'd0);
    check("R11 ctrl cleared by reset", 32'(gen_ctrl), 32'd0);
    check("R11 clksel cleared by reset", 32'(gen_clksel), 32'd0);
    check("R11 panic cleared by reset", panic_word, 32'd0);
    rd(BASE + 32'h1C);
    check("R11 scratch cleared by reset", rd_last, 32'd0);

    summary();
    $finish;
  end

endmodule